// File: doc/BRIEF.md
# Dithered Digital Pulse-Width Modulator with Frame Synchronisation

This block drives the switch of a power converter with a pulse-width modulated signal. A 9-bit frame counter runs from the fast system clock. A coded prescaler slows it by 1, 4 or 8. Each switching frame lasts a programmable number of counts. At the start of every frame the output is high, and it stays high for as many counts as the integer part of the duty word asks for.

A 6-bit fraction sits below the integer duty. When dithering is on, one extra count is added to some frames and not to others. Over 64 frames exactly as many frames get the extra count as the fraction says. The lengthened frames are spread out by taking the frame index in bit-reversed order. This gives an average duty with 15-bit resolution.

An external sync pin can cut a frame short and restart the counter. A rising edge is only accepted as a frame start if the pin was low for at least three counter ticks before it. The period, duty, speed code and dither enable are captured only at a frame start. Because of this, the control loop may rewrite the duty word on any clock without causing glitches mid-frame.

Top module: `dither_pwm`

## Requirements
- R1: While rst_n is low, pwm_o and frame_o are low. The first frame starts at the first rising clock edge after rst_n is released, so frame_o is high in the cycle that follows that edge.
- R2: The speed code selects the clocks per count: 00 gives 1, 01 gives 4, and both 10 and 11 give 8. The code is captured at the frame start. A free-running frame of P counts then lasts P times that many clocks.
- R3: With no accepted sync, a frame repeats every P counts, where P is period_i (P ≥ 1). frame_o is a single-clock pulse in the first cycle of each frame, when the counter is zero.
- R4: The integer duty D is duty_i[14:6]. With dithering off and 0 < D < P, pwm_o is high for the first D counts of the frame and low for the rest.
- R5: An effective duty of 0 keeps pwm_o low for the whole frame. An effective duty of P or more keeps it high for the whole frame.
- R6: period_i, duty_i, speed_i and dither_en_i are used only at a frame start. A change in the middle of a frame affects only the next frame.
- R7: Frames are numbered k = 0, 1, 2, … from the first frame after reset, and every frame start counts, including those caused by sync. Frame k gets one extra duty count only when dither_en_i is high and F = duty_i[5:0] is greater than the 6-bit bit-reverse of (k mod 64), where bit i moves to bit 5−i. With dither_en_i low, no extra count is ever added.
- R8: With F held fixed and dithering on, any 64 consecutive frames contain exactly F extra counts in total.
- R9: A sync edge is accepted when sync_en_i is high and sync_i rises after at least 3 consecutive low samples taken at the counter rate. An accepted edge restarts the counter at zero and starts a new frame. At a divide of 1, frame_o goes high after the third rising clock edge that follows the rise of sync_i, because of the two-stage input synchroniser. After that, free-running frames of P counts resume.
- R10: A sync rise is ignored when sync_en_i is low, or when the low time before it was fewer than 3 counter samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | 9 | Frame length in counts |
| duty_i | input | 15 | Duty word: integer counts in [14:6], dither fraction in [5:0] |
| speed_i | input | 2 | Prescaler code (00 ÷1, 01 ÷4, 1x ÷8) |
| dither_en_i | input | 1 | Enables fractional dithering |
| sync_en_i | input | 1 | Enables external frame restart |
| sync_i | input | 1 | Asynchronous frame sync input |
| pwm_o | output | 1 | Modulated switch drive |
| frame_o | output | 1 | One-clock strobe at each frame start |

## Verification
The assertions assume the following about the inputs:
- period_i is at least 1.
- The only way a frame ends early is a qualified sync edge.

The stimulus meets these assumptions in three ways:
- It uses periods of 2 or more.
- It changes inputs half a cycle away from the active edge.
- It writes the duty, period and speed in the middle of frames, so the frame-boundary capture is really tested.

Sync pulses are placed well inside long frames with the divide set to 1. The counter-rate low-time rule and the synchroniser latency can then be counted exactly. The free-running frame end never coincides with a sync edge.

// File: rtl/dpw_pkg.sv
package dpw_pkg;

    typedef enum logic [1:0] {
        SPD_FULL    = 2'b00,
        SPD_QUARTER = 2'b01,
        SPD_EIGHTH  = 2'b10,
        SPD_EIGHTHB = 2'b11
    } speed_e;

    localparam int unsigned DIV_FULL = 1;
    localparam int unsigned DIV_MID  = 4;
    localparam int unsigned DIV_SLOW = 8;

    // Clocks per counter step for a given speed code.
    function automatic int unsigned speed_div(input logic [1:0] code);
        case (speed_e'(code))
            SPD_FULL:    return DIV_FULL;
            SPD_QUARTER: return DIV_MID;
            default:     return DIV_SLOW;
        endcase
    endfunction

endpackage

// File: rtl/dpw_prescale.sv
module dpw_prescale
    import dpw_pkg::*;
#(
    parameter int PRE_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [1:0] speed_i,
    output logic       tick_o
);

    typedef struct packed {
        logic [1:0]       spd;
        logic [PRE_W-1:0] pre;
    } pre_st_t;

    pre_st_t          st_d, st_q;
    logic [PRE_W-1:0] lim;

    always_comb begin
        st_d   = st_q;
        lim    = PRE_W'(speed_div(st_q.spd) - 1);
        tick_o = (st_q.pre >= lim);
        if (tick_o) begin
            st_d.pre = '0;
        end else begin
            st_d.pre = st_q.pre + PRE_W'(1);
        end
        // New speed code only takes effect from a frame start onward.
        if (load_i) begin
            st_d.spd = speed_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dpw_sync_qual.sv
module dpw_sync_qual #(
    parameter int LOW_MIN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic en_i,
    input  logic sync_i,
    output logic accept_o
);

    localparam int              LOW_W   = $clog2(LOW_MIN + 1);
    localparam logic [LOW_W-1:0] LOW_LIM = LOW_W'(LOW_MIN);

    typedef struct packed {
        logic             meta;
        logic             sync_s;
        logic [LOW_W-1:0] low;
    } sq_st_t;

    sq_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = sync_i;
        st_d.sync_s = st_q.meta;
        accept_o    = tick_i && en_i && st_q.sync_s && (st_q.low >= LOW_LIM);
        // The low-time count advances at the counter rate and saturates at the limit.
        if (tick_i) begin
            if (st_q.sync_s) begin
                st_d.low = '0;
            end else if (st_q.low != LOW_LIM) begin
                st_d.low = st_q.low + LOW_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dpw_dither.sv
module dpw_dither #(
    parameter int FRAC_W = 6
) (
    input  logic [FRAC_W-1:0] frac_i,
    input  logic [FRAC_W-1:0] idx_i,
    input  logic              en_i,
    output logic              extra_o
);

    logic [FRAC_W-1:0] rev;

    for (genvar i = 0; i < FRAC_W; i++) begin : g_rev
        assign rev[i] = idx_i[FRAC_W-1-i];
    end

    // The bit-reversed index visits every value once per 2**FRAC_W frames,
    // so exactly frac_i frames in each window get the extra count.
    always_comb begin
        extra_o = en_i && (frac_i > rev);
    end

endmodule

// File: rtl/dither_pwm.sv
module dither_pwm
    import dpw_pkg::*;
#(
    parameter int CNT_W        = 9,
    parameter int FRAC_W       = 6,
    parameter int SYNC_LOW_MIN = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CNT_W-1:0]        period_i,
    input  logic [CNT_W+FRAC_W-1:0] duty_i,
    input  logic [1:0]              speed_i,
    input  logic                    dither_en_i,
    input  logic                    sync_en_i,
    input  logic                    sync_i,
    output logic                    pwm_o,
    output logic                    frame_o
);

    localparam int PRE_W  = $clog2(DIV_SLOW);
    localparam int DUTY_W = CNT_W + FRAC_W;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  per;
        logic [CNT_W:0]    eff;
        logic [FRAC_W-1:0] idx;
        logic              pwm;
        logic              frame;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     tick;
    logic     accept;
    logic     extra;
    logic     wrap;
    logic     start;

    dpw_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (start),
        .speed_i (speed_i),
        .tick_o  (tick)
    );

    dpw_sync_qual #(.LOW_MIN(SYNC_LOW_MIN)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .en_i     (sync_en_i),
        .sync_i   (sync_i),
        .accept_o (accept)
    );

    dpw_dither #(.FRAC_W(FRAC_W)) u_dith (
        .frac_i  (duty_i[FRAC_W-1:0]),
        .idx_i   (st_q.idx),
        .en_i    (dither_en_i),
        .extra_o (extra)
    );

    always_comb begin
        st_d       = st_q;
        st_d.frame = 1'b0;
        wrap  = ({1'b0, st_q.cnt} + (CNT_W+1)'(1)) >= {1'b0, st_q.per};
        start = tick && (wrap || accept);
        if (tick) begin
            if (start) begin
                // Frame boundary: capture the settings for the whole next frame.
                st_d.cnt   = '0;
                st_d.per   = period_i;
                st_d.eff   = {1'b0, duty_i[DUTY_W-1:FRAC_W]} + (CNT_W+1)'(extra);
                st_d.idx   = st_q.idx + FRAC_W'(1);
                st_d.frame = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
        st_d.pwm = ({1'b0, st_d.cnt} < st_d.eff);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_o   = st_q.pwm;
    assign frame_o = st_q.frame;

endmodule

// File: rtl/dither_pwm_chk.sv
module dither_pwm_chk #(
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwm_o,
    input logic             frame_o,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] per_q,
    input logic [CNT_W:0]   eff_q
);

    // R3: the strobe marks the first count of a frame
    p_strobe_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_o |-> (cnt_q == '0));

    // R3: the counter never reaches the captured period
    p_count_in_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (per_q > CNT_W'(1)) |-> (cnt_q < per_q));

    // R5: zero effective duty keeps the output low
    p_zero_duty_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_q == '0) |-> !pwm_o);

    // R5: effective duty at or above the period keeps the output high
    p_full_duty_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((per_q != '0) && (eff_q >= {1'b0, per_q})) |-> pwm_o);

    // R6: captured duty and period only move at a frame start
    p_frame_only_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_o |-> ($stable(eff_q) && $stable(per_q)));

endmodule

bind dither_pwm dither_pwm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwm_o   (pwm_o),
    .frame_o (frame_o),
    .cnt_q   (st_q.cnt),
    .per_q   (st_q.per),
    .eff_q   (st_q.eff)
);

// File: tb/dither_pwm_test.sv
module dither_pwm_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  period_i;
    logic [14:0] duty_i;
    logic [1:0]  speed_i;
    logic        dither_en_i;
    logic        sync_en_i;
    logic        sync_i;
    logic        pwm_o;
    logic        frame_o;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    dither_pwm uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .period_i    (period_i),
        .duty_i      (duty_i),
        .speed_i     (speed_i),
        .dither_en_i (dither_en_i),
        .sync_en_i   (sync_en_i),
        .sync_i      (sync_i),
        .pwm_o       (pwm_o),
        .frame_o     (frame_o)
    );

    function automatic int rev6(input int v);
        int r = 0;
        for (int i = 0; i < 6; i++) begin
            if (v[i]) r |= (1 << (5 - i));
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Frame monitor: expectations are built from the inputs seen at each frame start.
    bit    mon_en = 1'b1;
    bit    armed = 1'b0;
    bit    prev_frame = 1'b0;
    int    fcount = 0;
    int    hi_cnt = 0, len = 0;
    int    exp_hi = 0, exp_len = 0;
    int    last_hi = 0, last_len = 0;
    int    agg = 0;
    int    cur_d = 1, cur_p = 1, cur_eff = 0, cur_spd = 0;
    bit    cur_den = 1'b0;
    string tag_len, tag_hi;

    always @(negedge clk) begin
        if (!rst_n) begin
            fcount = 0; armed = 0; prev_frame = 0; exp_len = 0;
        end else begin
            if (frame_o) begin
                if (prev_frame && exp_len > 1)
                    chk(1'b0, "R3 frame strobe wider than one cycle", 2, 1);
                if (armed && mon_en) begin
                    tag_len = (cur_spd == 0) ? "R3 frame length" : "R2 prescaled frame length";
                    if (cur_den) tag_hi = "R7 dithered high time";
                    else if (cur_eff == 0 || cur_eff >= cur_p) tag_hi = "R5 saturated high time";
                    else tag_hi = "R4 high time";
                    chk(len == exp_len, tag_len, len, exp_len);
                    chk(hi_cnt == exp_hi, tag_hi, hi_cnt, exp_hi);
                    agg += hi_cnt / cur_d;
                end
                last_hi  = hi_cnt;
                last_len = len;
                cur_p   = int'(period_i);
                cur_spd = int'(speed_i);
                cur_d   = (speed_i == 2'b00) ? 1 : (speed_i == 2'b01) ? 4 : 8;
                cur_den = dither_en_i;
                cur_eff = int'(duty_i[14:6]) +
                          ((dither_en_i && (int'(duty_i[5:0]) > rev6(fcount % 64))) ? 1 : 0);
                exp_hi  = ((cur_eff < cur_p) ? cur_eff : cur_p) * cur_d;
                exp_len = cur_p * cur_d;
                armed   = mon_en;
                len     = 1;
                hi_cnt  = int'(pwm_o);
                fcount++;
            end else begin
                len++;
                hi_cnt += int'(pwm_o);
                if (!mon_en) armed = 0;
            end
            prev_frame = frame_o;
        end
    end

    task automatic wait_frame();
        @(negedge clk);
        while (frame_o !== 1'b1) @(negedge clk);
        #2;
    endtask

    task automatic set_cfg(input int p, input int d, input int f, input int spd, input bit den);
        period_i    = p[8:0];
        duty_i      = {d[8:0], f[5:0]};
        speed_i     = spd[1:0];
        dither_en_i = den;
    endtask

    task automatic count_frames(input int n, output int seen);
        seen = 0;
        repeat (n) begin
            @(negedge clk);
            seen += int'(frame_o);
        end
        #2;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seen;
        int n;
        bit f1, f2, f3;
        set_cfg(4, 2, 0, 0, 1'b0);
        sync_en_i = 1'b0;
        sync_i    = 1'b0;

        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            chk(pwm_o == 1'b0 && frame_o == 1'b0, "R1 outputs low in reset",
                int'({pwm_o, frame_o}), 0);
        end
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(frame_o == 1'b1, "R1 first frame after release", int'(frame_o), 1);
        #2;

        // R2 R3 R4 R5: sweep speed, period and integer duty
        for (int spd = 0; spd < 4; spd++) begin
            for (int p = 2; p <= 5; p++) begin
                for (int d = 0; d <= p + 1; d++) begin
                    wait_frame();
                    set_cfg(p, d, 0, spd, 1'b0);
                end
            end
        end

        // R6: mid-frame writes apply only from the next frame
        wait_frame();
        set_cfg(10, 3, 0, 0, 1'b0);
        wait_frame();
        repeat (2) @(negedge clk);
        #2 set_cfg(6, 8, 0, 1, 1'b0);
        wait_frame();
        chk(last_hi == 3, "R6 old duty kept for current frame", last_hi, 3);
        chk(last_len == 10, "R6 old period kept for current frame", last_len, 10);
        wait_frame();
        chk(last_hi == 24, "R6 new duty from next frame", last_hi, 24);
        chk(last_len == 24, "R6 new period and speed from next frame", last_len, 24);

        // R7 R8: dither windows of 64 frames
        begin
            int dvals [6] = '{5, 5, 5, 5, 5, 11};
            int fvals [6] = '{0, 1, 21, 32, 63, 63};
            for (int t = 0; t < 6; t++) begin
                wait_frame();
                set_cfg(12, dvals[t], fvals[t], 0, 1'b1);
                wait_frame();
                agg = 0;
                repeat (64) wait_frame();
                chk(agg == 64 * dvals[t] + fvals[t], "R8 extra counts over 64 frames",
                    agg, 64 * dvals[t] + fvals[t]);
            end
            wait_frame();
            set_cfg(12, 5, 63, 0, 1'b0);
            wait_frame();
            agg = 0;
            repeat (64) wait_frame();
            chk(agg == 64 * 5, "R7 no extra counts with dither disabled", agg, 320);
        end

        // R9 R10: external sync qualification
        wait_frame();
        set_cfg(40, 10, 0, 0, 1'b0);
        wait_frame();
        mon_en = 1'b0;
        sync_i = 1'b1;
        count_frames(6, seen);
        chk(seen == 0, "R10 sync ignored while disabled", seen, 0);
        sync_en_i = 1'b1;
        sync_i    = 1'b0;
        count_frames(2, seen);
        sync_i = 1'b1;
        count_frames(6, seen);
        chk(seen == 0, "R10 sync after short low time ignored", seen, 0);
        sync_i = 1'b0;
        count_frames(3, seen);
        sync_i = 1'b1;
        @(negedge clk); f1 = frame_o;
        @(negedge clk); f2 = frame_o;
        @(negedge clk); f3 = frame_o;
        chk(!f1 && !f2 && f3, "R9 sync restart latency", int'({f1, f2, f3}), 1);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (frame_o !== 1'b1);
        chk(n == 40, "R9 free-running resumes after sync", n, 40);
        #2;
        sync_i    = 1'b0;
        sync_en_i = 1'b0;
        mon_en    = 1'b1;
        wait_frame();
        set_cfg(7, 4, 0, 0, 1'b0);
        wait_frame();
        wait_frame();
        wait_frame();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule